// File: doc/BRIEF.md
# Serial Clock-Synthesizer Divider Loader

This block takes a 24-bit divider control word and a target index from a host, which writes them with a one-cycle write strobe. It sends the word bit by bit to an external programmable clock synthesizer over a three-wire link made of a serial clock, serial data and a bank of five latch strobes. Once the last bit has been clocked out, it raises the strobe of the chosen device for one serial-clock period so that the device copies the word into its divider register.

Before it starts a transfer, the block checks the fields of the word. A VCO divider below its minimum, a zero reference divider or a target index with no strobe behind it stops the transfer before it begins. In that case the block raises an error flag for one cycle and keeps the serial lines idle. While a transfer is running, `busy` is high and new writes have no effect. A one-cycle `done` pulse marks the end of the transfer.

Top module: `synth_loader`

## Requirements
- R1: The word goes out most significant bit first. Bit 23 is on `serData` at the first rising edge of `serClk` and bit 0 is on `serData` at the 24th, so the 24 values sampled at the rising edges rebuild the written word.
- R2: `serClk` idles low. Each low half and each high half lasts HALF_DIV system cycles, and the first rising edge comes HALF_DIV cycles after the accepting edge. `serData` changes only on the edge where `serClk` goes low, never while `serClk` is high.
- R3: The strobe begins at the edge of the 24th falling edge of `serClk`. For 2*HALF_DIV cycles, exactly `strobe[sel]` is high (bit i belongs to target index i). During that time `serClk` and `serData` stay low, and all three outputs are low once it ends.
- R4: A word whose VCO field, bits [8:0], is below 4 is rejected. `err` is high for exactly the one cycle after the write, `busy` stays low, and `serClk`, `serData` and `strobe` stay low.
- R5: A word whose reference field, bits [15:9], is 0 is rejected in the same way as in R4. The legal range of that field is 1 to 127.
- R6: A target index of 5, 6 or 7 is rejected in the same way as in R4, and no strobe is raised.
- R7: The output-divide field, bits [18:16], is accepted with any of its eight codes (000 selects ÷10, 001 ÷2, 010 ÷8, 011 ÷4, 100 ÷5, 101 ÷7, 110 ÷3, 111 ÷6). Bits [23:19] are not checked and are sent out unchanged.
- R8: `busy` goes high on the edge that accepts a write and stays high for exactly 50*HALF_DIV cycles, until the strobe ends. `done` is high for the single cycle after `busy` falls.
- R9: A write that arrives while `busy` is high is ignored. The running transfer keeps its word, its target and its length, and `err` stays low.
- R10: After reset, `busy`, `done`, `err`, `serClk`, `serData` and `strobe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | One-cycle write strobe from the host |
| wrWord | input | 24 | Divider control word to send |
| wrSel | input | 3 | Target device index, 0 to 4 |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| err | output | 1 | One-cycle pulse when a write is rejected |
| serClk | output | 1 | Serial clock to the synthesizers |
| serData | output | 1 | Serial data, sampled by the device on the rising edge of serClk |
| strobe | output | 5 | One-hot latch strobes, one per device |

## Verification
The hardest case to reach from the ports is a write that lands partway through a transfer. A run that only waits for `busy` to fall never shows whether such a write could corrupt the shift register or the stored target. The bench therefore injects a second write, with a different word and a different target, at a fixed sample inside the shifting phase. It then checks that the rebuilt word, the strobe index and the busy length all still match the first write. The field boundaries are reached by sweeping the VCO and reference fields across their edge values with all eight output-divide codes and all five targets. Rejected words are checked separately at each illegal value just below a boundary.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;

  localparam int WORD_W  = 24;
  localparam int VCO_LSB = 0;
  localparam int VCO_W   = 9;
  localparam int VCO_MIN = 4;
  localparam int REF_LSB = 9;
  localparam int REF_W   = 7;
  localparam int REF_MIN = 1;

  // strobes from control to datapath, at most one set per cycle except fall+stbOn
  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic stbOn;
    logic stbOff;
  } loadCtrl_t;

endpackage

// File: rtl/synth_field_check.sv
module synth_field_check
  import synth_loader_pkg::*;
#(
  parameter int NUM_TARGETS = 5,
  parameter int SEL_W       = 3
) (
  input  logic [WORD_W-1:0] wordIn,
  input  logic [SEL_W-1:0]  selIn,
  output logic              wordOk
);

  logic [VCO_W-1:0] vcoField;
  logic [REF_W-1:0] refField;
  logic vcoOk, refOk, selOk;

  assign vcoField = wordIn[VCO_LSB +: VCO_W];
  assign refField = wordIn[REF_LSB +: REF_W];

  assign vcoOk  = (vcoField >= VCO_W'(VCO_MIN));
  assign refOk  = (refField >= REF_W'(REF_MIN));
  assign selOk  = (selIn < SEL_W'(NUM_TARGETS));
  // output-divide field and top bits carry no illegal codes
  assign wordOk = vcoOk && refOk && selOk;

endmodule

// File: rtl/synth_loader_ctrl.sv
module synth_loader_ctrl
  import synth_loader_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wordOk,
  output loadCtrl_t ctl,
  output logic      busy,
  output logic      done,
  output logic      err
);

  localparam int CNT_W = $clog2(2 * HALF_DIV);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(2 * HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(WORD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STROBE} state_t;

  state_t           state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic [BIT_W-1:0] bitCnt, bitNx;
  logic             hi, hiNx;
  logic             doneNx, errNx;

  always_comb begin
    ctl     = '0;
    stateNx = state;
    cntNx   = cnt;
    hiNx    = hi;
    bitNx   = bitCnt;
    doneNx  = 1'b0;
    errNx   = 1'b0;
    case (state)
      S_IDLE: begin
        if (wrEn) begin
          if (wordOk) begin
            ctl.load = 1'b1;
            stateNx  = S_SHIFT;
            cntNx    = '0;
            hiNx     = 1'b0;
            bitNx    = '0;
          end else begin
            errNx = 1'b1;
          end
        end
      end
      S_SHIFT: begin
        if (cnt == HALF_LAST) begin
          cntNx = '0;
          if (!hi) begin
            hiNx     = 1'b1;
            ctl.rise = 1'b1;
          end else begin
            hiNx     = 1'b0;
            ctl.fall = 1'b1;
            if (bitCnt == BIT_LAST) begin
              stateNx   = S_STROBE;
              ctl.stbOn = 1'b1;
              bitNx     = '0;
            end else begin
              bitNx = bitCnt + 1'b1;
            end
          end
        end else begin
          cntNx = cnt + 1'b1;
        end
      end
      S_STROBE: begin
        if (cnt == STB_LAST) begin
          cntNx      = '0;
          ctl.stbOff = 1'b1;
          doneNx     = 1'b1;
          stateNx    = S_IDLE;
        end else begin
          cntNx = cnt + 1'b1;
        end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
      hi     <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      state  <= stateNx;
      cnt    <= cntNx;
      bitCnt <= bitNx;
      hi     <= hiNx;
      done   <= doneNx;
      err    <= errNx;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/synth_loader_dp.sv
module synth_loader_dp
  import synth_loader_pkg::*;
#(
  parameter int NUM_TARGETS = 5,
  parameter int SEL_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  loadCtrl_t              ctl,
  input  logic [WORD_W-1:0]      wrWord,
  input  logic [SEL_W-1:0]       wrSel,
  output logic                   serClk,
  output logic                   serData,
  output logic [NUM_TARGETS-1:0] strobe
);

  logic [WORD_W-1:0] shReg;
  logic [SEL_W-1:0]  selReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      selReg <= '0;
      serClk <= 1'b0;
    end else begin
      if (ctl.load) begin
        shReg  <= wrWord;
        selReg <= wrSel;
      end else if (ctl.fall) begin
        shReg <= {shReg[WORD_W-2:0], 1'b0};
      end
      if (ctl.rise) begin
        serClk <= 1'b1;
      end else if (ctl.fall) begin
        serClk <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_TARGETS; i++) begin : g_stb
    always_ff @(posedge clk) begin
      if (!rstN) begin
        strobe[i] <= 1'b0;
      end else if (ctl.stbOn) begin
        strobe[i] <= (selReg == SEL_W'(i));
      end else if (ctl.stbOff) begin
        strobe[i] <= 1'b0;
      end
    end
  end

  // after 24 shifts the register holds zeros, so data idles low
  assign serData = shReg[WORD_W-1];

endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synth_loader_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int NUM_TARGETS = 5,
  parameter int SEL_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [WORD_W-1:0]      wrWord,
  input  logic [SEL_W-1:0]       wrSel,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic                   serClk,
  output logic                   serData,
  output logic [NUM_TARGETS-1:0] strobe
);

  loadCtrl_t ctl;
  logic      wordOk;

  synth_field_check #(
    .NUM_TARGETS(NUM_TARGETS),
    .SEL_W      (SEL_W)
  ) u_check (
    .wordIn(wrWord),
    .selIn (wrSel),
    .wordOk(wordOk)
  );

  synth_loader_ctrl #(
    .HALF_DIV(HALF_DIV)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wordOk(wordOk),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done),
    .err   (err)
  );

  synth_loader_dp #(
    .NUM_TARGETS(NUM_TARGETS),
    .SEL_W      (SEL_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrWord (wrWord),
    .wrSel  (wrSel),
    .serClk (serClk),
    .serData(serData),
    .strobe (strobe)
  );

endmodule

// File: rtl/synth_loader_sva.sv
module synth_loader_sva
  import synth_loader_pkg::*;
#(
  parameter int NUM_TARGETS = 5,
  parameter int SEL_W       = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [WORD_W-1:0]      wrWord,
  input logic [SEL_W-1:0]       wrSel,
  input logic                   busy,
  input logic                   done,
  input logic                   err,
  input logic                   serClk,
  input logic                   serData,
  input logic [NUM_TARGETS-1:0] strobe
);

  // R1: first bit on the line is the top bit of the accepted word
  a_r1_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> serData == $past(wrWord[WORD_W-1]));

  // R2: data holds while the serial clock is high
  a_r2_data_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $stable(serData));

  // R3: at most one strobe, serial lines low meanwhile
  a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  a_r3_strobe_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe) |-> (!serClk && !serData));

  // R4: a rejected write never starts a transfer
  a_r4_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!busy && strobe == '0 && !serClk));

  // R8: strobe lies inside busy, done follows busy falling
  a_r8_strobe_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe) |-> busy);

  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R9: a write while busy raises no error
  a_r9_busy_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> !err);

endmodule

bind synth_loader synth_loader_sva #(
  .NUM_TARGETS(NUM_TARGETS),
  .SEL_W      (SEL_W)
) u_sva (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrWord (wrWord),
  .wrSel  (wrSel),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .serClk (serClk),
  .serData(serData),
  .strobe (strobe)
);

// File: tb/synth_loader_tb_top.sv
`timescale 1ns/1ps
module synth_loader_tb_top;

  localparam int H  = 2;
  localparam int NT = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [23:0] wrWord = '0;
  logic [2:0]  wrSel = '0;
  logic        busy, done, err, serClk, serData;
  logic [4:0]  strobe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  synth_loader #(.HALF_DIV(H), .NUM_TARGETS(NT), .SEL_W(3)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWord(wrWord), .wrSel(wrSel),
    .busy(busy), .done(done), .err(err), .serClk(serClk),
    .serData(serData), .strobe(strobe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doXfer(input logic [23:0] w, input int s, input int intrudeAt);
    logic [23:0] cap = '0;
    int rises = 0, badRise = 0, hiChange = 0;
    int stbCycles = 0, stbBad = 0, busyCycles = 0, errSeen = 0;
    logic prevClk = 1'b0, prevData = 1'b0;
    int idx = 1;
    @(negedge clk);
    wrEn = 1'b1; wrWord = w; wrSel = 3'(s);
    @(negedge clk);
    wrEn = 1'b0; wrWord = ~w;
    while (busy && idx < 1000) begin
      if (wrEn) wrEn = 1'b0;
      if (serClk && !prevClk) begin
        if (idx != (2 * rises + 1) * H + 1) badRise++;
        cap = {cap[22:0], serData};
        rises++;
      end
      if (serClk && prevClk && serData != prevData) hiChange++;
      if (strobe != '0) begin
        stbCycles++;
        if (strobe != (5'b1 << s) || serClk || serData || idx < 48 * H + 1) stbBad++;
      end
      if (err) errSeen++;
      if (idx == intrudeAt) begin
        wrEn = 1'b1; wrWord = ~w; wrSel = 3'((s + 1) % NT);
      end
      busyCycles++;
      prevClk = serClk; prevData = serData;
      @(negedge clk);
      idx++;
    end
    wrEn = 1'b0;
    check(busyCycles == 50 * H, "R8", "busy length", busyCycles, 50 * H);
    check(done == 1'b1, "R8", "done after busy", done, 1);
    check(cap == w, "R1", "rebuilt word", cap, w);
    check(cap[23:16] == w[23:16], "R7", "upper and divide bits", cap[23:16], w[23:16]);
    check(rises == 24, "R1", "rising edges", rises, 24);
    check(badRise == 0, "R2", "rise timing errors", badRise, 0);
    check(hiChange == 0, "R2", "data change while high", hiChange, 0);
    check(stbCycles == 2 * H, "R3", "strobe length", stbCycles, 2 * H);
    check(stbBad == 0, "R3", "strobe shape errors", stbBad, 0);
    if (intrudeAt > 0) check(errSeen == 0, "R9", "err during busy", errSeen, 0);
    @(negedge clk);
    check(done == 1'b0 && serClk == 1'b0 && serData == 1'b0 && strobe == '0,
          "R3", "idle after strobe", {done, serClk, serData, strobe}, 0);
  endtask

  task automatic doReject(input logic [23:0] w, input int s, input string req);
    int bad = 0;
    @(negedge clk);
    wrEn = 1'b1; wrWord = w; wrSel = 3'(s);
    @(negedge clk);
    wrEn = 1'b0;
    check(err == 1'b1 && busy == 1'b0, req, "err pulse, not busy", {err, busy}, 2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (err || busy || serClk || serData || strobe != '0) bad++;
    end
    check(bad == 0, req, "outputs idle after reject", bad, 0);
  endtask

  initial begin
    int vcoV[4] = '{4, 5, 300, 511};
    int refV[4] = '{1, 2, 64, 127};
    int n = 0;
    repeat (4) @(negedge clk);
    check({busy, done, err, serClk, serData, strobe} == '0, "R10", "reset outputs",
          {busy, done, err, serClk, serData, strobe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, err, serClk, serData, strobe} == '0, "R10", "idle after reset",
          {busy, done, err, serClk, serData, strobe}, 0);
    for (int vi = 0; vi < 4; vi++)
      for (int ri = 0; ri < 4; ri++)
        for (int d = 0; d < 8; d++) begin
          logic [4:0] up = 5'((vi * 11 + ri * 5 + d * 3 + 1) & 31);
          doXfer({up, 3'(d), 7'(refV[ri]), 9'(vcoV[vi])}, n % NT, 0);
          n++;
        end
    for (int v = 0; v < 4; v++) doReject({5'h1f, 3'd2, 7'd5, 9'(v)}, v % NT, "R4");
    doReject({5'h00, 3'd7, 7'd0, 9'd100}, 2, "R5");
    doReject({5'h15, 3'd1, 7'd0, 9'd511}, 0, "R5");
    for (int s = 5; s < 8; s++) doReject({5'h0a, 3'd3, 7'd20, 9'd40}, s, "R6");
    doXfer(24'hA5C3E7, 4, 10);
    doXfer(24'h3C0A09, 0, 40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    errors++;
    $display("FAIL R8 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule